// File: doc/BRIEF.md
# Sector Erase Accumulation Timer

This block sits between the command decoder of a NOR-style flash controller and its erase engine. The decoder hands it sector erase requests, each tagged with a sector index. The block collects those requests into a bit mask with one bit per sector. It keeps a collection window open until a full timeout passes with no further sector request. When the window closes, it hands the collected mask to the erase engine with a single-cycle start strobe.

A status bit reports the window state to the host. The bit reads 0 while more sectors can still be added. It reads 1 once the erase has been committed. From that point every command is dropped until the engine signals completion. A whole-chip erase request skips the window entirely.

The window length is a parameter counted in clock cycles. The default of 10000 cycles gives 50 µs at a 200 MHz clock.

Top module: `erase_gather`

## Requirements
- R1: In idle, a sector request with index i (and no chip request) opens the window on the next clock edge. The mask then holds only bit i, where bit i stands for sector i, and the status bit reads 0. The status bit is 0 whenever the block is idle or collecting.
- R2: A sector request accepted while the window is open sets the requested bit and leaves the other bits unchanged. A request for a sector whose bit is already set leaves the mask unchanged.
- R3: Every accepted sector request restarts the full timeout. The status bit rises on the clock edge that is exactly WINDOW_CYCLES edges after the edge that accepted the last sector request. A sector request present on that expiry edge is accepted and restarts the window instead. A chip request during the window neither restarts the timeout nor has any other effect.
- R4: The status bit rises on the edge where the window expires. On that same edge `eraseStart` goes high for exactly one cycle, with the collected mask on `eraseMask`.
- R5: While the status bit is 1, sector and chip requests are ignored, and the mask and status stay unchanged.
- R6: In idle, a chip request starts the erase on the next edge with no window. `eraseStart` pulses for one cycle, the mask becomes all ones, and the status bit becomes 1. If a chip request and a sector request arrive together in idle, the chip request takes priority.
- R7: `eraseDone` while the status bit is 1 clears the mask and the status bit on the next edge and returns the block to idle. `eraseDone` at any other time has no effect.
- R8: A synchronous active-high reset clears the mask, the timer, the status bit and `eraseStart`. After reset, no erase starts without a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secReqValid | input | 1 | Decoded sector erase request, valid for one cycle |
| secReqIdx | input | $clog2(NUM_SECTORS) | Sector index carried by the request |
| chipReqValid | input | 1 | Decoded whole-chip erase request |
| eraseDone | input | 1 | Completion report from the erase engine |
| eraseStart | output | 1 | One-cycle strobe that launches the erase engine |
| eraseMask | output | NUM_SECTORS | Sectors selected for erase; held stable while erasing |
| eraseStatus | output | 1 | Live status bit: 0 while idle or collecting, 1 once the erase is committed |

## Verification
The bench builds the block with eight sectors and a six-cycle window. At that size the expiry edge can be reached and counted exactly within a few vectors. This lets the bench hit a request landing on the very edge of expiry, a restart after a duplicate sector, and a chip request that is ignored mid-window. All of these are cycle-exact corner cases. Eight sectors also keep the all-ones mask of a chip erase, and both end bits (sector 0 and sector 7), within a readable vector table.

// File: rtl/erase_gather_pkg.sv
package erase_gather_pkg;

  // Control states of the collection window.
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BUSY    = 2'd2
  } gatherState_e;

  // Strobes from the control path into the datapath.
  typedef struct packed {
    logic loadFirst;   // mask <= one-hot of the request
    logic addSector;   // mask <= mask | one-hot of the request
    logic loadAll;     // mask <= all ones (chip erase)
    logic clearMask;   // mask <= 0
    logic timerClear;  // counter <= 0
    logic timerStep;   // counter <= counter + 1
  } dpStrobe_t;

endpackage

// File: rtl/erase_gather_dp.sv
module erase_gather_dp
  import erase_gather_pkg::*;
#(
  parameter int NUM_SECTORS   = 16,
  parameter int WINDOW_CYCLES = 10000,
  localparam int IDX_W = $clog2(NUM_SECTORS),
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dpStrobe_t              strobe,
  input  logic [IDX_W-1:0]       secReqIdx,
  output logic [NUM_SECTORS-1:0] sectorMask,
  output logic                   timerExpired
);

  logic [NUM_SECTORS-1:0] secOneHot;
  logic [CNT_W-1:0]       quietCount;

  // Decoder from sector index to one mask bit.
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : gen_decode
    assign secOneHot[g] = (secReqIdx == IDX_W'(g));
  end

  // Mask register.
  always_ff @(posedge clk) begin
    if (rst) begin
      sectorMask <= '0;
    end else if (strobe.clearMask) begin
      sectorMask <= '0;
    end else if (strobe.loadAll) begin
      sectorMask <= '1;
    end else if (strobe.loadFirst) begin
      sectorMask <= secOneHot;
    end else if (strobe.addSector) begin
      sectorMask <= sectorMask | secOneHot;
    end
  end

  // Count of quiet cycles since the last accepted request.
  always_ff @(posedge clk) begin
    if (rst || strobe.timerClear) begin
      quietCount <= '0;
    end else if (strobe.timerStep) begin
      quietCount <= quietCount + CNT_W'(1);
    end
  end

  assign timerExpired = (quietCount == CNT_W'(WINDOW_CYCLES - 1));

endmodule

// File: rtl/erase_gather_ctrl.sv
module erase_gather_ctrl
  import erase_gather_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      secReqValid,
  input  logic      chipReqValid,
  input  logic      eraseDone,
  input  logic      timerExpired,
  output dpStrobe_t strobe,
  output logic      eraseStart,
  output logic      statusBit
);

  gatherState_e state, stateNext;
  logic         startNext;

  always_comb begin
    stateNext = state;
    startNext = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (chipReqValid) begin
          strobe.loadAll = 1'b1;
          startNext      = 1'b1;
          stateNext      = ST_BUSY;
        end else if (secReqValid) begin
          strobe.loadFirst  = 1'b1;
          strobe.timerClear = 1'b1;
          stateNext         = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (secReqValid) begin
          strobe.addSector  = 1'b1;
          strobe.timerClear = 1'b1;
        end else if (timerExpired) begin
          startNext = 1'b1;
          stateNext = ST_BUSY;
        end else begin
          strobe.timerStep = 1'b1;
        end
      end
      ST_BUSY: begin
        if (eraseDone) begin
          strobe.clearMask  = 1'b1;
          strobe.timerClear = 1'b1;
          stateNext         = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      eraseStart <= 1'b0;
    end else begin
      state      <= stateNext;
      eraseStart <= startNext;
    end
  end

  assign statusBit = (state == ST_BUSY);

endmodule

// File: rtl/erase_gather.sv
module erase_gather
  import erase_gather_pkg::*;
#(
  parameter int NUM_SECTORS   = 16,
  parameter int WINDOW_CYCLES = 10000, // 50 us at 200 MHz
  localparam int IDX_W = $clog2(NUM_SECTORS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   secReqValid,
  input  logic [IDX_W-1:0]       secReqIdx,
  input  logic                   chipReqValid,
  input  logic                   eraseDone,
  output logic                   eraseStart,
  output logic [NUM_SECTORS-1:0] eraseMask,
  output logic                   eraseStatus
);

  dpStrobe_t strobe;
  logic      timerExpired;

  erase_gather_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .secReqValid  (secReqValid),
    .chipReqValid (chipReqValid),
    .eraseDone    (eraseDone),
    .timerExpired (timerExpired),
    .strobe       (strobe),
    .eraseStart   (eraseStart),
    .statusBit    (eraseStatus)
  );

  erase_gather_dp #(
    .NUM_SECTORS   (NUM_SECTORS),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .secReqIdx    (secReqIdx),
    .sectorMask   (eraseMask),
    .timerExpired (timerExpired)
  );

endmodule

// File: rtl/erase_gather_chk.sv
module erase_gather_chk #(
  parameter int NUM_SECTORS   = 16,
  parameter int WINDOW_CYCLES = 10000,
  localparam int IDX_W = $clog2(NUM_SECTORS)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   secReqValid,
  input logic [IDX_W-1:0]       secReqIdx,
  input logic                   chipReqValid,
  input logic                   eraseDone,
  input logic                   eraseStart,
  input logic [NUM_SECTORS-1:0] eraseMask,
  input logic                   eraseStatus
);

  logic        collecting;
  logic [31:0] quietSeen;

  assign collecting = !eraseStatus && (eraseMask != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      quietSeen <= '0;
    end else if (!eraseStatus && secReqValid) begin
      quietSeen <= '0;
    end else if (collecting) begin
      quietSeen <= quietSeen + 32'd1;
    end else begin
      quietSeen <= '0;
    end
  end

  AST_FIRST_SECTOR_SET: assert property (@(posedge clk) disable iff (rst)
    (!eraseStatus && secReqValid && !(chipReqValid && eraseMask == '0))
      |=> (!eraseStatus && eraseMask[$past(secReqIdx)])); // R1

  AST_MASK_GROWS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (collecting && !eraseStatus) |=> ((eraseMask & $past(eraseMask)) == $past(eraseMask))); // R2

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    collecting |-> (quietSeen < WINDOW_CYCLES)); // R3

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eraseStart |=> !eraseStart); // R4

  AST_START_WITH_STATUS: assert property (@(posedge clk) disable iff (rst)
    eraseStart |-> (eraseStatus && $rose(eraseStatus))); // R4

  AST_LOCKED_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (eraseStatus && !eraseDone) |=> (eraseStatus && $stable(eraseMask))); // R5

  AST_CHIP_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    (!eraseStatus && eraseMask == '0 && chipReqValid) |=> (eraseStart && eraseMask == '1)); // R6

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (eraseStatus && eraseDone) |=> (!eraseStatus && eraseMask == '0)); // R7

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!eraseStart && !eraseStatus && eraseMask == '0)); // R8

endmodule

bind erase_gather erase_gather_chk #(
  .NUM_SECTORS   (NUM_SECTORS),
  .WINDOW_CYCLES (WINDOW_CYCLES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .secReqValid  (secReqValid),
  .secReqIdx    (secReqIdx),
  .chipReqValid (chipReqValid),
  .eraseDone    (eraseDone),
  .eraseStart   (eraseStart),
  .eraseMask    (eraseMask),
  .eraseStatus  (eraseStatus)
);

// File: tb/tb_erase_gather.sv
`timescale 1ns/1ps
module tb_erase_gather;

  localparam int NS = 8;
  localparam int W  = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         secReqValid = 1'b0;
  logic [2:0]   secReqIdx = '0;
  logic         chipReqValid = 1'b0;
  logic         eraseDone = 1'b0;
  logic         eraseStart;
  logic [NS-1:0] eraseMask;
  logic         eraseStatus;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  erase_gather #(.NUM_SECTORS(NS), .WINDOW_CYCLES(W)) dut (
    .clk(clk), .rst(rst), .secReqValid(secReqValid), .secReqIdx(secReqIdx),
    .chipReqValid(chipReqValid), .eraseDone(eraseDone),
    .eraseStart(eraseStart), .eraseMask(eraseMask), .eraseStatus(eraseStatus)
  );

  // {sec, idx[3], chip, done, expStart, expStatus, expMask[8], req[4]}
  localparam logic [19:0] VEC [19] = '{
    {1'b1, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 4'd1}, // R1 first sector
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 4'd3}, // R3 quiet 1
    {1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 8'h24, 4'd2}, // R2 add sector
    {1'b1, 3'd5, 1'b0, 1'b0, 1'b0, 1'b0, 8'h24, 4'd2}, // R2 duplicate, restart
    {1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h24, 4'd6}, // R6 chip ignored mid-window
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h24, 4'd3},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h24, 4'd3},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h24, 4'd3},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h24, 4'd3},
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h24, 4'd4}, // R4 expiry
    {1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h24, 4'd5}, // R5 sector ignored
    {1'b0, 3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h24, 4'd5}, // R5 chip ignored
    {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd7}, // R7 done clears
    {1'b0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 4'd6}, // R6 chip erase
    {1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 4'd4},
    {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd7},
    {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd7}, // R7 done in idle ignored
    {1'b1, 3'd7, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 4'd6}, // R6 chip wins
    {1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'd7}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic checkAll(input string req, input logic s, input logic st,
                          input logic [NS-1:0] m);
    check(req, "eraseStart", 32'(eraseStart), 32'(s));
    check(req, "eraseStatus", 32'(eraseStatus), 32'(st));
    check(req, "eraseMask", 32'(eraseMask), 32'(m));
  endtask

  task automatic step(input logic sv, input logic [2:0] idx,
                      input logic chip, input logic done);
    @(negedge clk);
    secReqValid = sv; secReqIdx = idx; chipReqValid = chip; eraseDone = done;
    @(posedge clk);
    #1;
    secReqValid = 1'b0; chipReqValid = 1'b0; eraseDone = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checkAll("R8", 1'b0, 1'b0, '0);
    @(negedge clk);
    rst = 1'b0;

    foreach (VEC[i]) begin
      step(VEC[i][19], VEC[i][18:16], VEC[i][15], VEC[i][14]);
      checkAll($sformatf("R%0d", VEC[i][3:0]), VEC[i][13], VEC[i][12], VEC[i][11:4]);
    end

    // R3: request on the expiry edge is accepted and restarts the window
    step(1'b1, 3'd1, 1'b0, 1'b0);
    checkAll("R1", 1'b0, 1'b0, 8'h02);
    for (int k = 0; k < W - 1; k++) step(1'b0, 3'd0, 1'b0, 1'b0);
    step(1'b1, 3'd3, 1'b0, 1'b0);
    checkAll("R3", 1'b0, 1'b0, 8'h0A);
    for (int k = 0; k < W - 1; k++) step(1'b0, 3'd0, 1'b0, 1'b0);
    checkAll("R3", 1'b0, 1'b0, 8'h0A);
    step(1'b0, 3'd0, 1'b0, 1'b0);
    checkAll("R4", 1'b1, 1'b1, 8'h0A);
    step(1'b0, 3'd0, 1'b0, 1'b1);
    checkAll("R7", 1'b0, 1'b0, 8'h00);

    // R8: reset in the middle of a window
    step(1'b1, 3'd4, 1'b0, 1'b0);
    step(1'b0, 3'd0, 1'b0, 1'b0);
    step(1'b0, 3'd0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    checkAll("R8", 1'b0, 1'b0, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < W + 2; k++) begin
      step(1'b0, 3'd0, 1'b0, 1'b0);
      checkAll("R8", 1'b0, 1'b0, 8'h00);
    end
    step(1'b1, 3'd6, 1'b0, 1'b0);
    checkAll("R1", 1'b0, 1'b0, 8'h40);

    finishRun();
  end

endmodule